// File: doc/BRIEF.md
# Clock Mode Transition Controller

This block holds the clock configuration of a small microcontroller and decides which configuration changes may take effect. Software writes a full configuration word (source selects, oscillator run and halt bits, divider fields) or a control word (low-power entry, oscillation-stop detection, error clear) through a simple write port. Each request is checked against a sparse table of legal moves between clock modes and against the preconditions of the move. A legal request takes effect on the next clock edge. An illegal one changes nothing and sets a sticky error flag.

The outputs drive the clock tree: a source select, the CPU divide ratio, one enable per oscillator (main, sub, PLL, on-chip), a CPU clock gate and a 3-bit mode code. Wait and stop are left only through the interrupt input, which passes through a configurable synchronizer. The block then returns to the mode that was running before entry.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the mode code is 0 (main clock), the source select is 0, the ratio is 8, only the main oscillator enable and the CPU clock gate are high, and the error flag is low.
- R2: The configuration word (address 0) holds: sub oscillator run in bit 0, main halt in bit 1, divide-by-8 override in bit 2, sub select in bit 3, divider field in bits 5:4, PLL select in bit 6 and on-chip select in bit 7. With the override set, the ratio is 8. Otherwise a field of 0, 1, 2 or 3 gives 1, 2, 4 or 16.
- R3: Mode codes are main 0, sub 1, sub low-power 2, PLL 3, on-chip 4, on-chip low-power 5, wait 6 and stop 7. Source select codes are main 0, sub 1, PLL 2 and on-chip 3. The legal moves are main–sub, main–on-chip, sub–sub low-power, sub–on-chip, on-chip–on-chip low-power and on-chip to sub, plus any change that stays within one mode. Any other move is rejected. So is a word with more than one select, a halted main clock with no sub or on-chip select, or any write made during wait or stop.
- R4: The PLL mode is entered only from the main mode and left only to the main mode.
- R5: A word that selects the sub clock is rejected unless the same word keeps the sub oscillator running. Sub oscillator on/off changes are accepted in other modes.
- R6: An accepted word with main halt set always takes effect with the divide-by-8 override set.
- R7: A move from on-chip to main is rejected unless the override is already set in the current configuration.
- R8: A move that halts a running main clock is rejected while oscillation-stop detection (control bit 2, rewritten on every control write) is enabled.
- R9: Control bit 0 (address 1) enters stop. In stop, all four oscillator enables and the CPU gate are low. Stop requests from PLL mode are rejected.
- R10: Control bit 1 enters wait, with the oscillator enables kept and the CPU gate low. Wait requests from PLL mode are rejected.
- R11: An interrupt during wait or stop returns to the previous mode. Leaving stop sets the override, so the ratio becomes 8. Leaving wait keeps the divider.
- R12: The error flag stays set until a control write with bit 3 set. A rejection in the same write still leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Word select: 0 configuration, 1 control |
| wr_data | input | 8 | Write data |
| irq | input | 1 | Wake-up interrupt |
| mode_o | output | 3 | Current mode code |
| src_sel_o | output | 2 | CPU clock source select |
| div_ratio_o | output | 5 | CPU divide ratio (1, 2, 4, 8, 16) |
| main_osc_en_o | output | 1 | Main oscillator enable |
| sub_osc_en_o | output | 1 | Sub oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| ring_osc_en_o | output | 1 | On-chip oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate |
| err_o | output | 1 | Sticky rejection flag |

## Verification
The assertions assume that an interrupt does not arrive in the same cycle as a write that enters wait or stop. They also assume that the synchronized interrupt has fallen before the next low-power entry. Otherwise a wake-up could fold into the entry cycle and hide the low-power state. The bench drives the interrupt only while the block sits in wait or stop. It holds the line for longer than the synchronizer depth, then keeps it low for several cycles before any further write. All writes are placed between clock edges, one per cycle, and every result is sampled one full cycle later.

// File: rtl/clkm_pkg.sv
package clkm_pkg;

   typedef enum logic [2:0] {
      MD_MAIN    = 3'd0,
      MD_SUB     = 3'd1,
      MD_SUB_LP  = 3'd2,
      MD_PLL     = 3'd3,
      MD_RING    = 3'd4,
      MD_RING_LP = 3'd5,
      MD_WAIT    = 3'd6,
      MD_STOP    = 3'd7
   } clk_mode_e;

   typedef enum logic [1:0] {
      LP_RUN  = 2'd0,
      LP_WAIT = 2'd1,
      LP_STOP = 2'd2
   } lp_state_e;

   typedef struct packed {
      logic       sel_ring;
      logic       sel_pll;
      logic [1:0] div_fld;
      logic       sel_sub;
      logic       div8;
      logic       main_halt;
      logic       sub_run;
   } clk_cfg_t;

   localparam int RATIO_W = 5;

   function automatic clk_mode_e mode_of(input logic pll, input logic ring,
                                         input logic sub, input logic halt);
      if (pll)       return MD_PLL;
      else if (ring) return halt ? MD_RING_LP : MD_RING;
      else if (sub)  return halt ? MD_SUB_LP : MD_SUB;
      else           return MD_MAIN;
   endfunction

   function automatic logic [RATIO_W-1:0] ratio_of(input logic d8, input logic [1:0] fld);
      if (d8) return RATIO_W'(8);
      case (fld)
         2'd0:    return RATIO_W'(1);
         2'd1:    return RATIO_W'(2);
         2'd2:    return RATIO_W'(4);
         default: return RATIO_W'(16);
      endcase
   endfunction

endpackage

// File: rtl/clkm_irq_sync.sv
module clkm_irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_in,
   output logic irq_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign irq_out = irq_in;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else if (STAGES == 1) sh_q <= irq_in;
            else sh_q <= {sh_q[(STAGES > 1 ? STAGES-2 : 0):0], irq_in};
         end
         assign irq_out = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/clkm_guard.sv
module clkm_guard
   import clkm_pkg::*;
(
   input  clk_mode_e cur_mode,
   input  clk_mode_e new_mode,
   input  logic      n_sel_sub,
   input  logic      n_sel_pll,
   input  logic      n_sel_ring,
   input  logic      n_sub_run,
   input  logic      n_main_halt,
   input  logic      c_div8,
   input  logic      c_main_halt,
   input  logic      det_en,
   output logic      accept
);
   logic shape_ok, edge_ok, pre_ok;

   always_comb begin
      shape_ok = ($countones({n_sel_sub, n_sel_pll, n_sel_ring}) <= 1)
               && !(n_sel_sub && !n_sub_run)
               && !(n_main_halt && !n_sel_sub && !n_sel_ring);

      edge_ok = 1'b0;
      if (cur_mode == new_mode) edge_ok = 1'b1;
      else begin
         case (cur_mode)
            MD_MAIN:    edge_ok = (new_mode == MD_SUB) || (new_mode == MD_PLL) ||
                                  (new_mode == MD_RING);
            MD_SUB:     edge_ok = (new_mode == MD_MAIN) || (new_mode == MD_SUB_LP) ||
                                  (new_mode == MD_RING);
            MD_SUB_LP:  edge_ok = (new_mode == MD_SUB);
            MD_PLL:     edge_ok = (new_mode == MD_MAIN);
            MD_RING:    edge_ok = (new_mode == MD_MAIN) || (new_mode == MD_SUB) ||
                                  (new_mode == MD_RING_LP);
            MD_RING_LP: edge_ok = (new_mode == MD_RING);
            default:    edge_ok = 1'b0;
         endcase
      end

      pre_ok = !(cur_mode == MD_RING && new_mode == MD_MAIN && !c_div8)
             && !(n_main_halt && !c_main_halt && det_en);

      accept = shape_ok && edge_ok && pre_ok;
   end
endmodule

// File: rtl/clkm_outmap.sv
module clkm_outmap
   import clkm_pkg::*;
(
   input  clk_cfg_t             cfg,
   input  lp_state_e            lp,
   output clk_mode_e            run_mode,
   output logic [2:0]           mode_code,
   output logic [1:0]           src_sel,
   output logic [RATIO_W-1:0]   ratio,
   output logic                 main_en,
   output logic                 sub_en,
   output logic                 pll_en,
   output logic                 ring_en,
   output logic                 cpu_en
);
   logic stopped;

   always_comb begin
      run_mode = mode_of(cfg.sel_pll, cfg.sel_ring, cfg.sel_sub, cfg.main_halt);
      case (lp)
         LP_WAIT: mode_code = MD_WAIT;
         LP_STOP: mode_code = MD_STOP;
         default: mode_code = run_mode;
      endcase

      if (cfg.sel_pll)       src_sel = 2'd2;
      else if (cfg.sel_ring) src_sel = 2'd3;
      else if (cfg.sel_sub)  src_sel = 2'd1;
      else                   src_sel = 2'd0;

      ratio   = ratio_of(cfg.div8, cfg.div_fld);
      stopped = (lp == LP_STOP);
      main_en = !cfg.main_halt && !stopped;
      sub_en  = cfg.sub_run    && !stopped;
      pll_en  = cfg.sel_pll    && !stopped;
      ring_en = cfg.sel_ring   && !stopped;
      cpu_en  = (lp == LP_RUN);
   end
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
   import clkm_pkg::*;
#(
   parameter int           ADDR_W    = 2,
   parameter int           CFG_ADDR  = 0,
   parameter int           CTL_ADDR  = 1,
   parameter int           IRQ_SYNC  = 2,
   parameter logic [7:0]   RESET_CFG = 8'h04
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [7:0]           wr_data,
   input  logic                 irq,
   output logic [2:0]           mode_o,
   output logic [1:0]           src_sel_o,
   output logic [RATIO_W-1:0]   div_ratio_o,
   output logic                 main_osc_en_o,
   output logic                 sub_osc_en_o,
   output logic                 pll_en_o,
   output logic                 ring_osc_en_o,
   output logic                 cpu_clk_en_o,
   output logic                 err_o
);
   localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);
   localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);
   localparam int B_STOP = 0;
   localparam int B_WAIT = 1;
   localparam int B_DET  = 2;
   localparam int B_CLR  = 3;

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
         $error("ADDR_W out of range");
      end
      if (CFG_ADDR == CTL_ADDR) begin : g_bad_map
         $error("configuration and control addresses collide");
      end
      if (CFG_ADDR >= (1 << ADDR_W) || CTL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("address does not fit ADDR_W");
      end
      if (IRQ_SYNC < 0 || IRQ_SYNC > 4) begin : g_bad_sync
         $error("IRQ_SYNC must be 0 to 4");
      end
   endgenerate

   clk_cfg_t  cfg_q, new_cfg, applied;
   lp_state_e lp_q;
   logic      det_q, err_q;
   logic      cfg_wr, ctl_wr, irq_s, accept;
   clk_mode_e run_mode, new_mode;

   clkm_irq_sync #(.STAGES(IRQ_SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .irq_in(irq), .irq_out(irq_s)
   );

   always_comb begin
      cfg_wr   = wr_en && (wr_addr == CFG_A);
      ctl_wr   = wr_en && (wr_addr == CTL_A);
      new_cfg  = clk_cfg_t'(wr_data);
      applied  = new_cfg;
      applied.div8 = new_cfg.div8 | new_cfg.main_halt;
      new_mode = mode_of(new_cfg.sel_pll, new_cfg.sel_ring, new_cfg.sel_sub,
                         new_cfg.main_halt);
   end

   clkm_guard u_guard (
      .cur_mode   (run_mode),
      .new_mode   (new_mode),
      .n_sel_sub  (new_cfg.sel_sub),
      .n_sel_pll  (new_cfg.sel_pll),
      .n_sel_ring (new_cfg.sel_ring),
      .n_sub_run  (new_cfg.sub_run),
      .n_main_halt(new_cfg.main_halt),
      .c_div8     (cfg_q.div8),
      .c_main_halt(cfg_q.main_halt),
      .det_en     (det_q),
      .accept     (accept)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= clk_cfg_t'(RESET_CFG);
         lp_q  <= LP_RUN;
         det_q <= 1'b0;
         err_q <= 1'b0;
      end else if (lp_q != LP_RUN) begin
         if (irq_s) begin
            lp_q <= LP_RUN;
            if (lp_q == LP_STOP) cfg_q.div8 <= 1'b1;
         end
         if (cfg_wr || ctl_wr) err_q <= 1'b1;
      end else begin
         if (cfg_wr) begin
            if (accept) cfg_q <= applied;
            else        err_q <= 1'b1;
         end
         if (ctl_wr) begin
            det_q <= wr_data[B_DET];
            if (wr_data[B_CLR]) err_q <= 1'b0;
            if ((wr_data[B_STOP] || wr_data[B_WAIT]) && run_mode == MD_PLL)
               err_q <= 1'b1;
            else if (wr_data[B_STOP])
               lp_q <= LP_STOP;
            else if (wr_data[B_WAIT])
               lp_q <= LP_WAIT;
         end
      end
   end

   clkm_outmap u_out (
      .cfg      (cfg_q),
      .lp       (lp_q),
      .run_mode (run_mode),
      .mode_code(mode_o),
      .src_sel  (src_sel_o),
      .ratio    (div_ratio_o),
      .main_en  (main_osc_en_o),
      .sub_en   (sub_osc_en_o),
      .pll_en   (pll_en_o),
      .ring_en  (ring_osc_en_o),
      .cpu_en   (cpu_clk_en_o)
   );

   assign err_o = err_q;
endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mode_o,
   input logic [1:0] src_sel_o,
   input logic [4:0] div_ratio_o,
   input logic       main_osc_en_o,
   input logic       sub_osc_en_o,
   input logic       pll_en_o,
   input logic       ring_osc_en_o,
   input logic       cpu_clk_en_o,
   input logic       err_o
);
   localparam logic [2:0] M_MAIN = 3'd0;
   localparam logic [2:0] M_PLL  = 3'd3;
   localparam logic [2:0] M_WAIT = 3'd6;
   localparam logic [2:0] M_STOP = 3'd7;

   assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == M_STOP) |-> !(main_osc_en_o || sub_osc_en_o || pll_en_o ||
                               ring_osc_en_o || cpu_clk_en_o));

   assert_wait_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == M_WAIT) |-> !cpu_clk_en_o);

   assert_pll_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == M_PLL && $past(mode_o) != M_PLL) |-> $past(mode_o) == M_MAIN);

   assert_pll_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_o) == M_PLL && mode_o != M_PLL) |-> mode_o == M_MAIN);

   assert_stop_exit_div8_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_o) == M_STOP && mode_o != M_STOP) |-> div_ratio_o == 5'd8);

   assert_sub_needs_osc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel_o == 2'd1 && mode_o != M_STOP) |-> sub_osc_en_o);

   assert_reject_keeps_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(err_o) && $past(mode_o) != M_WAIT && $past(mode_o) != M_STOP)
      |-> ($stable(src_sel_o) && $stable(div_ratio_o) && $stable(mode_o)));
endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .src_sel_o(src_sel_o),
   .div_ratio_o(div_ratio_o), .main_osc_en_o(main_osc_en_o),
   .sub_osc_en_o(sub_osc_en_o), .pll_en_o(pll_en_o),
   .ring_osc_en_o(ring_osc_en_o), .cpu_clk_en_o(cpu_clk_en_o), .err_o(err_o)
);

// File: tb/sim_clk_mode_ctrl.sv
`timescale 1ns/1ps
module sim_clk_mode_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       irq = 1'b0;
   logic [2:0] mode_o;
   logic [1:0] src_sel_o;
   logic [4:0] div_ratio_o;
   logic       main_osc_en_o, sub_osc_en_o, pll_en_o, ring_osc_en_o, cpu_clk_en_o, err_o;

   int n_run = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   clk_mode_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .irq(irq), .mode_o(mode_o), .src_sel_o(src_sel_o), .div_ratio_o(div_ratio_o),
      .main_osc_en_o(main_osc_en_o), .sub_osc_en_o(sub_osc_en_o), .pll_en_o(pll_en_o),
      .ring_osc_en_o(ring_osc_en_o), .cpu_clk_en_o(cpu_clk_en_o), .err_o(err_o)
   );

   // entry: req(4) addr(1) data(8) mode(3) src(2) ratio(5) err(1) = 24 bits
   localparam int NV = 32;
   localparam logic [23:0] VEC [NV] = '{
      {4'd2,  1'b0, 8'h00, 3'd0, 2'd0, 5'd1,  1'b0},  // R2 field 0
      {4'd2,  1'b0, 8'h10, 3'd0, 2'd0, 5'd2,  1'b0},  // R2 field 1
      {4'd2,  1'b0, 8'h20, 3'd0, 2'd0, 5'd4,  1'b0},  // R2 field 2
      {4'd2,  1'b0, 8'h30, 3'd0, 2'd0, 5'd16, 1'b0},  // R2 field 3
      {4'd2,  1'b0, 8'h34, 3'd0, 2'd0, 5'd8,  1'b0},  // R2 override
      {4'd5,  1'b0, 8'h08, 3'd0, 2'd0, 5'd8,  1'b1},  // R5 sub select, osc off
      {4'd12, 1'b1, 8'h08, 3'd0, 2'd0, 5'd8,  1'b0},  // R12 clear
      {4'd5,  1'b0, 8'h01, 3'd0, 2'd0, 5'd1,  1'b0},  // R5 sub osc on in main
      {4'd3,  1'b0, 8'h09, 3'd1, 2'd1, 5'd1,  1'b0},  // R3 main -> sub
      {4'd4,  1'b0, 8'h41, 3'd1, 2'd1, 5'd1,  1'b1},  // R4 sub -> PLL rejected
      {4'd12, 1'b1, 8'h08, 3'd1, 2'd1, 5'd1,  1'b0},  // R12
      {4'd6,  1'b0, 8'h0B, 3'd2, 2'd1, 5'd8,  1'b0},  // R6 halt forces /8
      {4'd3,  1'b0, 8'h05, 3'd2, 2'd1, 5'd8,  1'b1},  // R3 sub lp -> main illegal
      {4'd12, 1'b1, 8'h08, 3'd2, 2'd1, 5'd8,  1'b0},  // R12
      {4'd3,  1'b0, 8'h09, 3'd1, 2'd1, 5'd1,  1'b0},  // R3 sub lp -> sub
      {4'd3,  1'b0, 8'h01, 3'd0, 2'd0, 5'd1,  1'b0},  // R3 sub -> main
      {4'd4,  1'b0, 8'h40, 3'd3, 2'd2, 5'd1,  1'b0},  // R4 main -> PLL
      {4'd4,  1'b0, 8'h80, 3'd3, 2'd2, 5'd1,  1'b1},  // R4 PLL -> on-chip rejected
      {4'd12, 1'b1, 8'h08, 3'd3, 2'd2, 5'd1,  1'b0},  // R12
      {4'd9,  1'b1, 8'h01, 3'd3, 2'd2, 5'd1,  1'b1},  // R9 stop from PLL rejected
      {4'd12, 1'b1, 8'h08, 3'd3, 2'd2, 5'd1,  1'b0},  // R12
      {4'd4,  1'b0, 8'h00, 3'd0, 2'd0, 5'd1,  1'b0},  // R4 PLL -> main
      {4'd3,  1'b0, 8'h80, 3'd4, 2'd3, 5'd1,  1'b0},  // R3 main -> on-chip
      {4'd7,  1'b0, 8'h00, 3'd4, 2'd3, 5'd1,  1'b1},  // R7 no override yet
      {4'd12, 1'b1, 8'h08, 3'd4, 2'd3, 5'd1,  1'b0},  // R12
      {4'd7,  1'b0, 8'h84, 3'd4, 2'd3, 5'd8,  1'b0},  // R7 set override
      {4'd8,  1'b1, 8'h04, 3'd4, 2'd3, 5'd8,  1'b0},  // R8 detection on
      {4'd8,  1'b0, 8'h86, 3'd4, 2'd3, 5'd8,  1'b1},  // R8 halt blocked
      {4'd8,  1'b1, 8'h08, 3'd4, 2'd3, 5'd8,  1'b0},  // R8 detection off, clear
      {4'd8,  1'b0, 8'h86, 3'd5, 2'd3, 5'd8,  1'b0},  // R8 on-chip low power
      {4'd3,  1'b0, 8'h84, 3'd4, 2'd3, 5'd8,  1'b0},  // R3 back to on-chip
      {4'd7,  1'b0, 8'h04, 3'd0, 2'd0, 5'd8,  1'b0}   // R7 on-chip -> main
   };

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wake();
      @(negedge clk);
      irq = 1'b1;
      repeat (4) @(negedge clk);
      irq = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 mode", mode_o, 0);
      check("R1 src", src_sel_o, 0);
      check("R1 ratio", div_ratio_o, 8);
      check("R1 enables", {main_osc_en_o, sub_osc_en_o, pll_en_o, ring_osc_en_o}, 4'b1000);
      check("R1 cpu gate", cpu_clk_en_o, 1);
      check("R1 err", err_o, 0);

      for (int i = 0; i < NV; i++) begin
         logic [23:0] v;
         string tag;
         v = VEC[i];
         wr({1'b0, v[19]}, v[18:11]);
         tag = $sformatf("R%0d row %0d", v[23:20], i);
         check({tag, " mode"}, mode_o, v[10:8]);
         check({tag, " src"}, src_sel_o, v[7:6]);
         check({tag, " ratio"}, div_ratio_o, v[5:1]);
         check({tag, " err"}, err_o, v[0]);
      end

      // R10 wait keeps enables, gates the CPU
      wr(2'd0, 8'h11);
      check("R2 ratio 2", div_ratio_o, 2);
      wr(2'd1, 8'h02);
      check("R10 mode", mode_o, 6);
      check("R10 cpu gate", cpu_clk_en_o, 0);
      check("R10 enables", {main_osc_en_o, sub_osc_en_o}, 2'b11);
      wake();
      check("R11 wait exit mode", mode_o, 0);
      check("R11 wait exit ratio", div_ratio_o, 2);
      check("R11 cpu gate", cpu_clk_en_o, 1);

      // R9 stop, R3 write during stop, R11 stop exit
      wr(2'd1, 8'h01);
      check("R9 mode", mode_o, 7);
      check("R9 enables", {main_osc_en_o, sub_osc_en_o, pll_en_o, ring_osc_en_o, cpu_clk_en_o}, 0);
      wr(2'd0, 8'h00);
      check("R3 write in stop err", err_o, 1);
      check("R3 write in stop mode", mode_o, 7);
      wake();
      check("R11 stop exit mode", mode_o, 0);
      check("R11 stop exit ratio", div_ratio_o, 8);
      wr(2'd1, 8'h08);
      check("R12 cleared", err_o, 0);

      // R11 stop from sub returns to sub
      wr(2'd0, 8'h09);
      check("R3 sub", mode_o, 1);
      wr(2'd1, 8'h01);
      check("R9 stop from sub", mode_o, 7);
      wake();
      check("R11 back to sub", mode_o, 1);
      check("R11 sub ratio", div_ratio_o, 8);

      // R12 set wins over clear, R10 wait from PLL rejected
      wr(2'd0, 8'h01);
      wr(2'd0, 8'h41);
      check("R4 PLL", mode_o, 3);
      wr(2'd1, 8'h09);
      check("R12 set wins", err_o, 1);
      check("R12 mode kept", mode_o, 3);
      wr(2'd1, 8'h08);
      wr(2'd1, 8'h02);
      check("R10 wait from PLL err", err_o, 1);
      check("R10 wait from PLL mode", mode_o, 3);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end
endmodule